// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block is the per-processor end of a prioritised interrupt fabric. It decides which interrupt the processor is shown. It keeps a 32-bit request word made of the processor's current priority threshold and the number of the one source waiting to be taken. Beside the word it keeps the priority of that waiting source and the priority of a software-raised inter-processor interrupt (IPI). A smaller priority value always means more urgent. A source controller offers sources to the block. Each offer is kept or sent back at once. A kept source that a more urgent one displaces is returned to the controller through a reject notice.

The processor side has four operations: write the threshold, write the IPI priority, accept (read and claim the waiting source), and signal end of service. Accepting claims the source and raises the threshold to that source's priority. End of service restores the threshold, tells the source controller which source has finished, and asks it to resend anything it is holding back. Every notice to the source controller is a registered pulse one cycle long that carries a source number.

Top module: `irq_present_unit`

## Requirements
- R1: After reset, accept_value reads 0: the threshold is in bits 31:24 and the waiting source number is in bits 23:0. The waiting priority is 0, the IPI priority is 0xFF and irq_out is low.
- R2: An offer is sent back on the offer reject lane in either of two cases: its priority is greater than or equal to the threshold, or a source is waiting whose priority is less than or equal to the offered one.
- R3: An offer that is kept replaces any source already waiting, and the displaced source is reported on the offer reject lane. The new number and priority are latched and irq_out goes high.
- R4: Writing the IPI priority with a value below the threshold runs the IPI check. The IPI loses only to a waiting source whose priority is less than or equal to the IPI priority. When the IPI wins, the displaced source is reported on the processor reject lane, the waiting number becomes IPI_SRC (default 2) and the waiting priority becomes the IPI priority.
- R5: Writing a threshold lower than the old one clears the waiting source, drops irq_out and reports the source on the processor reject lane, but only when a source is waiting and the new threshold is less than or equal to its priority. Otherwise the lower threshold is simply stored.
- R6: Writing a threshold greater than or equal to the old one triggers a resend.
- R7: An accept leaves the waiting priority in bits 31:24 and zero in bits 23:0, and drops irq_out. Before the accept, accept_value holds the full word the processor reads.
- R8: An end-of-service write loads bits 31:24 of the written word as the threshold, pulses eoi_valid with bits 23:0 as eoi_src, and then triggers a resend.
- R9: A resend first runs the IPI check when the IPI priority is below the threshold, then pulses resend_valid.
- R10: Every notice appears in the cycle after the operation that causes it and lasts one cycle. The processor reject lane, eoi_valid and resend_valid stay low after a cycle with no processor operation.
- R11: At most one processor operation is asserted per cycle. An offer in the same cycle is judged against the state left by that operation.
- R12: A waiting number of zero means nothing is waiting, and irq_out is high exactly when bits 23:0 of accept_value are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Source controller offers a source this cycle |
| offer_src | input | 24 | Offered source number (nonzero, not IPI_SRC) |
| offer_prio | input | 8 | Offered priority |
| cppr_wr | input | 1 | Processor writes the threshold |
| cppr_val | input | 8 | New threshold |
| ipi_wr | input | 1 | Processor writes the IPI priority |
| ipi_val | input | 8 | New IPI priority |
| accept_rd | input | 1 | Processor accepts the waiting source |
| eoi_wr | input | 1 | Processor signals end of service |
| eoi_val | input | 32 | Threshold to restore (31:24) and finished source (23:0) |
| accept_value | output | 32 | Current request word |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_proc_valid | output | 1 | Reject notice caused by a processor operation |
| rej_proc_src | output | 24 | Source rejected by that operation |
| rej_offer_valid | output | 1 | Reject notice caused by an offer |
| rej_offer_src | output | 24 | Source rejected by that offer |
| eoi_valid | output | 1 | End-of-service notice |
| eoi_src | output | 24 | Source that finished service |
| resend_valid | output | 1 | Request to the source controller to resend held sources |

## Verification
An offer and a processor operation can arrive in the same clock cycle. The case that matters most is an IPI write or a threshold change landing in the cycle of an offer. The bench provokes it in directed steps: a threshold raise together with an offer that is kept only under the new threshold, and an IPI write that displaces a waiting source while a still more urgent offer displaces the IPI. Random cycles also mix offers freely with processor operations. A bench model applies the processor operation first and the offer second, and it predicts both reject lanes and the final word.

// File: rtl/irq_present_pkg.sv
package irq_present_pkg;

    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int REG_W  = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    // Request word: threshold on top, waiting source below.
    typedef struct packed {
        prio_t cppr;
        src_t  src;
    } req_t;

    // Complete server state.
    typedef struct packed {
        req_t  req;
        prio_t pend;
        prio_t ipi;
    } srv_t;

    // A notice to the source controller.
    typedef struct packed {
        logic valid;
        src_t src;
    } note_t;

    // Result of one state-transforming step.
    typedef struct packed {
        srv_t  s;
        note_t rej;
    } step_t;

    function automatic logic is_pending(srv_t s);
        return s.req.src != '0;
    endfunction

    // IPI competes against whatever is waiting.
    function automatic step_t ipi_check(srv_t s, src_t ipi_src);
        step_t r;
        r.s   = s;
        r.rej = '0;
        if (!(is_pending(s) && (s.pend <= s.ipi))) begin
            if (is_pending(s)) begin
                r.rej.valid = 1'b1;
                r.rej.src   = s.req.src;
            end
            r.s.req.src = ipi_src;
            r.s.pend    = s.ipi;
        end
        return r;
    endfunction

    // IPI check gated by the threshold.
    function automatic step_t gated_ipi(srv_t s, src_t ipi_src);
        step_t r;
        r.s   = s;
        r.rej = '0;
        if (s.ipi < s.req.cppr) begin
            r = ipi_check(s, ipi_src);
        end
        return r;
    endfunction

endpackage

// File: rtl/ipp_proc_stage.sv
module ipp_proc_stage
    import irq_present_pkg::*;
#(
    parameter src_t IPI_SRC = 24'd2
) (
    input  srv_t  cur,
    input  logic  cppr_wr,
    input  prio_t cppr_val,
    input  logic  ipi_wr,
    input  prio_t ipi_val,
    input  logic  accept_rd,
    input  logic  eoi_wr,
    input  req_t  eoi_val,
    output srv_t  nxt,
    output note_t rej,
    output note_t eoi,
    output logic  resend
);

    always_comb begin
        step_t st;
        st.s   = cur;
        st.rej = '0;
        eoi    = '0;
        resend = 1'b0;
        if (cppr_wr) begin
            st.s.req.cppr = cppr_val;
            if (cppr_val < cur.req.cppr) begin
                if (is_pending(cur) && (cppr_val <= cur.pend)) begin
                    st.rej.valid  = 1'b1;
                    st.rej.src    = cur.req.src;
                    st.s.req.src  = '0;
                end
            end else begin
                st     = gated_ipi(st.s, IPI_SRC);
                resend = 1'b1;
            end
        end else if (ipi_wr) begin
            st.s.ipi = ipi_val;
            st       = gated_ipi(st.s, IPI_SRC);
        end else if (accept_rd) begin
            st.s.req.cppr = cur.pend;
            st.s.req.src  = '0;
        end else if (eoi_wr) begin
            st.s.req.cppr = eoi_val.cppr;
            eoi.valid     = 1'b1;
            eoi.src       = eoi_val.src;
            st            = gated_ipi(st.s, IPI_SRC);
            resend        = 1'b1;
        end
        nxt = st.s;
        rej = st.rej;
    end

endmodule

// File: rtl/ipp_offer_stage.sv
module ipp_offer_stage
    import irq_present_pkg::*;
(
    input  srv_t  cur,
    input  logic  offer_valid,
    input  src_t  offer_src,
    input  prio_t offer_prio,
    output srv_t  nxt,
    output note_t rej
);

    logic refuse;

    always_comb begin
        refuse = (offer_prio >= cur.req.cppr) ||
                 (is_pending(cur) && (cur.pend <= offer_prio));
        nxt = cur;
        rej = '0;
        if (offer_valid) begin
            if (refuse) begin
                rej.valid = 1'b1;
                rej.src   = offer_src;
            end else begin
                if (is_pending(cur)) begin
                    rej.valid = 1'b1;
                    rej.src   = cur.req.src;
                end
                nxt.req.src = offer_src;
                nxt.pend    = offer_prio;
            end
        end
    end

endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
    import irq_present_pkg::*;
#(
    parameter src_t IPI_SRC = 24'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic              cppr_wr,
    input  logic [PRIO_W-1:0] cppr_val,
    input  logic              ipi_wr,
    input  logic [PRIO_W-1:0] ipi_val,
    input  logic              accept_rd,
    input  logic              eoi_wr,
    input  logic [REG_W-1:0]  eoi_val,
    output logic [REG_W-1:0]  accept_value,
    output logic              irq_out,
    output logic              rej_proc_valid,
    output logic [SRC_W-1:0]  rej_proc_src,
    output logic              rej_offer_valid,
    output logic [SRC_W-1:0]  rej_offer_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_valid
);

    srv_t  state_q, mid_s, next_s;
    note_t rej_p_d, rej_o_d, eoi_d;
    note_t rej_p_q, rej_o_q, eoi_q;
    logic  resend_d, resend_q, irq_q;

    // Processor operation is applied first, the offer second.
    ipp_proc_stage #(.IPI_SRC(IPI_SRC)) u_proc (
        .cur       (state_q),
        .cppr_wr   (cppr_wr),
        .cppr_val  (cppr_val),
        .ipi_wr    (ipi_wr),
        .ipi_val   (ipi_val),
        .accept_rd (accept_rd),
        .eoi_wr    (eoi_wr),
        .eoi_val   (req_t'(eoi_val)),
        .nxt       (mid_s),
        .rej       (rej_p_d),
        .eoi       (eoi_d),
        .resend    (resend_d)
    );

    ipp_offer_stage u_offer (
        .cur         (mid_s),
        .offer_valid (offer_valid),
        .offer_src   (offer_src),
        .offer_prio  (offer_prio),
        .nxt         (next_s),
        .rej         (rej_o_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.req  <= '0;
            state_q.pend <= '0;
            state_q.ipi  <= '1;
            irq_q        <= 1'b0;
            rej_p_q      <= '0;
            rej_o_q      <= '0;
            eoi_q        <= '0;
            resend_q     <= 1'b0;
        end else begin
            state_q  <= next_s;
            irq_q    <= is_pending(next_s);
            rej_p_q  <= rej_p_d;
            rej_o_q  <= rej_o_d;
            eoi_q    <= eoi_d;
            resend_q <= resend_d;
        end
    end

    assign accept_value    = state_q.req;
    assign irq_out         = irq_q;
    assign rej_proc_valid  = rej_p_q.valid;
    assign rej_proc_src    = rej_p_q.src;
    assign rej_offer_valid = rej_o_q.valid;
    assign rej_offer_src   = rej_o_q.src;
    assign eoi_valid       = eoi_q.valid;
    assign eoi_src         = eoi_q.src;
    assign resend_valid    = resend_q;

endmodule

// File: rtl/irq_present_chk.sv
module irq_present_chk
    import irq_present_pkg::*;
#(
    parameter src_t IPI_SRC = 24'd2
) (
    input logic              clk,
    input logic              rst,
    input logic              offer_valid,
    input logic [SRC_W-1:0]  offer_src,
    input logic [PRIO_W-1:0] offer_prio,
    input logic              cppr_wr,
    input logic [PRIO_W-1:0] cppr_val,
    input logic              ipi_wr,
    input logic [PRIO_W-1:0] ipi_val,
    input logic              accept_rd,
    input logic              eoi_wr,
    input logic [REG_W-1:0]  eoi_val,
    input logic [REG_W-1:0]  accept_value,
    input logic              irq_out,
    input logic              rej_proc_valid,
    input logic [SRC_W-1:0]  rej_proc_src,
    input logic              rej_offer_valid,
    input logic [SRC_W-1:0]  rej_offer_src,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src,
    input logic              resend_valid
);

    logic proc_any;
    assign proc_any = cppr_wr | ipi_wr | accept_rd | eoi_wr;

    assert_irq_tracks_wait_R12: assert property (@(posedge clk) disable iff (rst)
        irq_out == (accept_value[SRC_W-1:0] != '0));

    assert_ops_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cppr_wr, ipi_wr, accept_rd, eoi_wr}));

    assert_offer_refused_R2: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !proc_any && (offer_prio >= accept_value[REG_W-1:SRC_W]))
        |=> (rej_offer_valid && (rej_offer_src == $past(offer_src))));

    assert_accept_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (accept_rd && !offer_valid) |=> ((accept_value[SRC_W-1:0] == '0) && !irq_out));

    assert_eoi_forward_R8: assert property (@(posedge clk) disable iff (rst)
        eoi_wr |=> (eoi_valid && (eoi_src == $past(eoi_val[SRC_W-1:0])) && resend_valid &&
                    (accept_value[REG_W-1:SRC_W] == $past(eoi_val[REG_W-1:SRC_W]))));

    assert_raise_resends_R6: assert property (@(posedge clk) disable iff (rst)
        (cppr_wr && (cppr_val >= accept_value[REG_W-1:SRC_W])) |=> resend_valid);

    assert_ipi_wins_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (ipi_wr && !offer_valid && (ipi_val < accept_value[REG_W-1:SRC_W]) &&
         (accept_value[SRC_W-1:0] == '0))
        |=> ((accept_value[SRC_W-1:0] == IPI_SRC) && irq_out));

    assert_lower_rejects_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (cppr_wr && !offer_valid && (cppr_val < accept_value[REG_W-1:SRC_W]))
        |=> (!rej_proc_valid || (rej_proc_src == $past(accept_value[SRC_W-1:0]))));

    assert_quiet_proc_lane_R10: assert property (@(posedge clk) disable iff (rst)
        !(cppr_wr || ipi_wr || eoi_wr) |=> (!rej_proc_valid && !resend_valid && !eoi_valid));

endmodule

bind irq_present_unit irq_present_chk #(.IPI_SRC(IPI_SRC)) u_chk (.*);

// File: tb/sim_irq_present_unit.sv
module sim_irq_present_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] IPI_NUM = 24'd2;

    logic        clk = 1'b0;
    logic        rst;
    logic        offer_valid;
    logic [23:0] offer_src;
    logic [7:0]  offer_prio;
    logic        cppr_wr;
    logic [7:0]  cppr_val;
    logic        ipi_wr;
    logic [7:0]  ipi_val;
    logic        accept_rd;
    logic        eoi_wr;
    logic [31:0] eoi_val;
    logic [31:0] accept_value;
    logic        irq_out;
    logic        rej_proc_valid;
    logic [23:0] rej_proc_src;
    logic        rej_offer_valid;
    logic [23:0] rej_offer_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model state
    logic [7:0]  m_cppr, m_pend, m_ipi;
    logic [23:0] m_src;
    logic [24:0] x_rp, x_ro, x_eoi;
    logic        x_rs;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_present_unit #(.IPI_SRC(IPI_NUM)) u0 (.*);

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic m_ipi_contest();
        if (!((m_src != 0) && (m_pend <= m_ipi))) begin
            if (m_src != 0) x_rp = {1'b1, m_src};
            m_src  = IPI_NUM;
            m_pend = m_ipi;
        end
    endtask

    task automatic m_resend();
        if (m_ipi < m_cppr) m_ipi_contest();
        x_rs = 1'b1;
    endtask

    // op: 0 none, 1 threshold write, 2 IPI write, 3 accept, 4 end of service
    task automatic model(bit ov, logic [23:0] os, logic [7:0] op_prio, int op, logic [31:0] v);
        logic [7:0] old;
        x_rp = '0; x_ro = '0; x_eoi = '0; x_rs = 1'b0;
        case (op)
            1: begin
                old = m_cppr;
                m_cppr = v[7:0];
                if (v[7:0] < old) begin
                    if ((m_src != 0) && (v[7:0] <= m_pend)) begin
                        x_rp = {1'b1, m_src};
                        m_src = '0;
                    end
                end else m_resend();
            end
            2: begin
                m_ipi = v[7:0];
                if (m_ipi < m_cppr) m_ipi_contest();
            end
            3: begin
                m_cppr = m_pend;
                m_src  = '0;
            end
            4: begin
                m_cppr = v[31:24];
                x_eoi  = {1'b1, v[23:0]};
                m_resend();
            end
            default: ;
        endcase
        if (ov) begin
            if ((op_prio >= m_cppr) || ((m_src != 0) && (m_pend <= op_prio)))
                x_ro = {1'b1, os};
            else begin
                if (m_src != 0) x_ro = {1'b1, m_src};
                m_src  = os;
                m_pend = op_prio;
            end
        end
    endtask

    task automatic compare(string tag);
        check(tag, "word", accept_value, {m_cppr, m_src});
        check(tag, "irq", {31'd0, irq_out}, {31'd0, (m_src != 0)});
        check(tag, "rej_proc", {7'd0, rej_proc_valid, rej_proc_src}, {7'd0, x_rp});
        check(tag, "rej_offer", {7'd0, rej_offer_valid, rej_offer_src}, {7'd0, x_ro});
        check(tag, "eoi", {7'd0, eoi_valid, eoi_src}, {7'd0, x_eoi});
        check(tag, "resend", {31'd0, resend_valid}, {31'd0, x_rs});
    endtask

    // Called at a falling edge; compares after the next rising edge.
    task automatic step(string tag, bit ov, logic [23:0] os, logic [7:0] op_prio,
                        int op, logic [31:0] v);
        offer_valid = ov;
        offer_src   = os;
        offer_prio  = op_prio;
        cppr_wr     = (op == 1);
        ipi_wr      = (op == 2);
        accept_rd   = (op == 3);
        eoi_wr      = (op == 4);
        cppr_val    = v[7:0];
        ipi_val     = v[7:0];
        eoi_val     = v;
        model(ov, os, op_prio, op, v);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [7:0] rnd_prio();
        logic [31:0] r = $urandom();
        return (r[4:0] == 5'd0) ? 8'hFF : {4'd0, r[11:8]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_r;
        seed_r = $urandom(32'h5EED_0042);
        rst = 1'b1;
        offer_valid = 0; offer_src = 0; offer_prio = 0;
        cppr_wr = 0; cppr_val = 0; ipi_wr = 0; ipi_val = 0;
        accept_rd = 0; eoi_wr = 0; eoi_val = 0;
        m_cppr = 0; m_src = 0; m_pend = 0; m_ipi = 8'hFF;
        x_rp = 0; x_ro = 0; x_eoi = 0; x_rs = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");                                    // reset state
        step("R2", 1, 24'd5, 8'd3, 0, 0);                  // threshold 0 refuses all
        step("R1", 0, 0, 0, 1, 32'h10);                   // raise: reset IPI 0xFF stays out
        step("R6", 0, 0, 0, 1, 32'h10);                   // equal write resends
        step("R3", 1, 24'd5, 8'd8, 0, 0);                 // kept, irq up
        step("R2", 1, 24'd6, 8'd8, 0, 0);                 // tie with waiting refused
        step("R3", 1, 24'd7, 8'd4, 0, 0);                 // displaces 5
        step("R10", 0, 0, 0, 0, 0);                       // pulses gone
        step("R4", 0, 0, 0, 2, 32'h6);                    // IPI loses to prio 4
        step("R4", 0, 0, 0, 2, 32'h2);                    // IPI wins, rejects 7
        step("R7", 0, 0, 0, 3, 0);                        // accept
        step("R12", 0, 0, 0, 0, 0);                       // nothing waiting, irq low
        step("R2", 1, 24'd8, 8'd2, 0, 0);                 // equal to threshold refused
        step("R8", 0, 0, 0, 4, 32'h1000_0002);            // EOI, IPI relatched
        step("R9", 0, 0, 0, 2, 32'hFF);
        step("R7", 0, 0, 0, 3, 0);
        step("R9", 0, 0, 0, 4, 32'h1000_0002);            // resend only
        step("R3", 1, 24'd9, 8'd5, 0, 0);
        step("R5", 0, 0, 0, 1, 32'h06);                   // lower but above waiting
        step("R5", 0, 0, 0, 1, 32'h05);                   // clears 9
        step("R11", 1, 24'd12, 8'h18, 1, 32'h20);         // raise then offer kept
        step("R11", 1, 24'd13, 8'h00, 2, 32'h01);         // both reject lanes
        step("R7", 0, 0, 0, 3, 0);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom();
            int op = (r[2:0] < 5) ? int'(r[2:0]) : 0;
            logic [31:0] v = (op == 4) ? {rnd_prio(), 24'd0 + r[15:8]} : {24'd0, rnd_prio()};
            step("R11", r[3], 24'd3 + r[23:16], rnd_prio(), op, v);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule